// File: doc/BRIEF.md
# User-Data Information-Unit Deframer

This block sits behind a consumer-format digital audio receiver and takes the user-data channel one bit at a time, each bit marked by a valid strobe. It drops every zero that pads the stream between information units (IUs) and between messages. It assembles each IU into one byte and writes the bytes into a fill bank. A long enough run of zeros after an IU marks the end of a message. The fill bank then becomes the host-readable bank, and the other bank starts collecting the next message.

The host sees the last complete message through a combinational read port (`rd_addr` to `rd_data`). It also sees a count of the bytes in that message, a maskable update flag and a sticky overflow flag. Both flags clear on a one-cycle status-read strobe.

The framing is a three-state machine:
- **ST_IDLE**: no message is in progress.
- **ST_CAPTURE**: an IU is being shifted in.
- **ST_GAP**: zeros are being counted after an IU.

Its transitions are:
- **T_START**: ST_IDLE to ST_CAPTURE on a valid 1.
- **T_BYTE**: ST_CAPTURE to ST_GAP on the eighth IU bit.
- **T_NEXT**: ST_GAP to ST_CAPTURE on a valid 1.
- **T_END**: ST_GAP to ST_IDLE on the ninth consecutive valid zero.

Every other case holds the state.

Top module: `iu_deframer`

## Requirements
- R1: After reset `irq_flag`, `ovf_flag` and `msg_len` are 0.
- R2: Valid zeros seen in ST_IDLE, and runs of zero to eight valid zeros between IUs, are dropped. They add no byte, and the message carries on across them.
- R3: An IU starts at a valid 1 and takes eight valid bits. The stored byte holds the first bit received (always 1) in bit 7 and the last bit received in bit 0.
- R4: The ninth consecutive valid zero after an IU ends the message. One cycle later, byte k of the message (k counted from 0) reads back at `rd_addr` = k.
- R5: While the next message is being collected, the readable message and `msg_len` stay unchanged.
- R6: `msg_len` gives the number of bytes in the last completed message.
- R7: `irq_flag` becomes 1 when a message completes while `irq_mask` is 1. It stays 0 when `irq_mask` is 0.
- R8: A cycle with `status_rd` high clears `irq_flag` and `ovf_flag`. If a message completes in that same cycle, `irq_flag` is set instead of cleared.
- R9: In a message longer than 96 IUs, only the first 96 bytes are kept and `msg_len` reads 96. `ovf_flag` is set and stays set until `status_rd`.
- R10: `ubit` is ignored in cycles where `ubit_valid` is 0.
- R11: `rd_data` reads 0 for any `rd_addr` of 96 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ubit_valid | input | 1 | Qualifies `ubit` in this cycle |
| ubit | input | 1 | Recovered user-data bit |
| irq_mask | input | 1 | Enables setting of `irq_flag` |
| status_rd | input | 1 | Status-read strobe; clears both flags |
| rd_addr | input | 7 | Byte index into the readable message |
| rd_data | output | 8 | Byte at `rd_addr` (combinational) |
| msg_len | output | 7 | Byte count of the readable message |
| irq_flag | output | 1 | Buffer-updated flag |
| ovf_flag | output | 1 | Sticky message-overflow flag |

## Verification
The assertions assume `ubit_valid` and `ubit` are clean synchronous levels, held for one clock per bit. They also assume `status_rd` is a strobe whose effect is judged against the completion pulse of that same edge. The stimulus drives every input only at the falling edge and inserts occasional valid-low stall cycles with `ubit` held at 1.

Messages are always ended with a full run of nine zeros, and idle cycles follow before the host-side ports are sampled. A completion pulse therefore never lands in an unintended cycle, except in the single test that aims a status read exactly at the completion edge.

// File: rtl/iu_pkg.sv
package iu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_GAP     = 2'd2
    } iu_state_e;
endpackage

// File: rtl/iu_deframe_fsm.sv
module iu_deframe_fsm
    import iu_pkg::*;
#(
    parameter int IU_BITS   = 8,
    parameter int END_ZEROS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic               byte_valid,
    output logic [IU_BITS-1:0] byte_data,
    output logic               msg_end
);
    localparam int BCW = $clog2(IU_BITS + 1);
    localparam int ZCW = $clog2(END_ZEROS + 1);
    localparam logic [BCW-1:0] LAST_BIT  = BCW'(IU_BITS - 1);
    localparam logic [ZCW-1:0] LAST_ZERO = ZCW'(END_ZEROS - 1);

    iu_state_e          state_q, state_d;
    logic [BCW-1:0]     bit_cnt_q;
    logic [ZCW-1:0]     zcnt_q;
    logic [IU_BITS-1:0] shreg_q;
    logic               byte_valid_q, msg_end_q;
    logic [IU_BITS-1:0] byte_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions T_START, T_BYTE, T_NEXT, T_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_valid && bit_in) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (bit_valid && bit_cnt_q == LAST_BIT) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (bit_valid && bit_in)                          state_d = ST_CAPTURE;
                else if (bit_valid && !bit_in && zcnt_q == LAST_ZERO) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q    <= '0;
            zcnt_q       <= '0;
            shreg_q      <= '0;
            byte_valid_q <= 1'b0;
            byte_q       <= '0;
            msg_end_q    <= 1'b0;
        end else begin
            byte_valid_q <= 1'b0;
            msg_end_q    <= 1'b0;
            if (bit_valid) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (bit_in) begin
                            shreg_q   <= IU_BITS'(1);
                            bit_cnt_q <= BCW'(1);
                        end
                    end
                    ST_CAPTURE: begin
                        shreg_q   <= {shreg_q[IU_BITS-2:0], bit_in};
                        bit_cnt_q <= bit_cnt_q + BCW'(1);
                        if (bit_cnt_q == LAST_BIT) begin
                            byte_valid_q <= 1'b1;
                            byte_q       <= {shreg_q[IU_BITS-2:0], bit_in};
                            zcnt_q       <= '0;
                        end
                    end
                    ST_GAP: begin
                        if (bit_in) begin
                            shreg_q   <= IU_BITS'(1);
                            bit_cnt_q <= BCW'(1);
                        end else begin
                            zcnt_q <= zcnt_q + ZCW'(1);
                            if (zcnt_q == LAST_ZERO) msg_end_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_valid = byte_valid_q;
    assign byte_data  = byte_q;
    assign msg_end    = msg_end_q;

    // R3
    iu_lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_q |-> byte_q[IU_BITS-1]);

    // R4
    end_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end_q |-> (state_q == ST_IDLE && $past(state_q) == ST_GAP));

    // R4
    no_dual_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid_q && msg_end_q));

    // R2
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (zcnt_q <= LAST_ZERO));
endmodule

// File: rtl/iu_msg_store.sv
module iu_msg_store #(
    parameter int DEPTH = 96,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid,
    input  logic [W-1:0]               byte_data,
    input  logic                       msg_end,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH+1)-1:0] msg_len,
    output logic                       ovf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [AW:0]   LIM_C  = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [0:1][0:DEPTH-1];
    logic          fill_sel_q;
    logic [CW-1:0] wr_cnt_q, len_q;
    logic          ovf_q;
    logic          room;

    assign room = (wr_cnt_q < FULL_C);

    always_ff @(posedge clk) begin
        if (byte_valid && room) mem[fill_sel_q][wr_cnt_q[AW-1:0]] <= byte_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_sel_q <= 1'b0;
            wr_cnt_q   <= '0;
            len_q      <= '0;
            ovf_q      <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (msg_end) begin
                fill_sel_q <= ~fill_sel_q;
                len_q      <= wr_cnt_q;
                wr_cnt_q   <= '0;
            end else if (byte_valid) begin
                if (room) wr_cnt_q <= wr_cnt_q + CW'(1);
                else      ovf_q    <= 1'b1;
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < LIM_C) rd_data = mem[~fill_sel_q][rd_addr[AW-1:0]];
        else                         rd_data = '0;
    end

    assign msg_len = len_q;
    assign ovf_evt = ovf_q;

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= FULL_C);

    // R9
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (wr_cnt_q == FULL_C));

    // R5
    len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(msg_end) |-> $stable(len_q));
endmodule

// File: rtl/iu_irq_flags.sv
module iu_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_end,
    input  logic ovf_evt,
    input  logic irq_mask,
    input  logic status_rd,
    output logic irq_flag,
    output logic ovf_flag
);
    logic irq_q, ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (msg_end && irq_mask) irq_q <= 1'b1;
            else if (status_rd)      irq_q <= 1'b0;
            if (ovf_evt)             ovf_q <= 1'b1;
            else if (status_rd)      ovf_q <= 1'b0;
        end
    end

    assign irq_flag = irq_q;
    assign ovf_flag = ovf_q;

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(irq_mask) && $past(msg_end)));

    // R8
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_rd) && !$past(msg_end)) |-> !irq_q);

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_q) && !$past(status_rd)) |-> ovf_q);
endmodule

// File: rtl/iu_deframer.sv
module iu_deframer #(
    parameter int IU_BITS   = 8,
    parameter int END_ZEROS = 9,
    parameter int DEPTH     = 96
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ubit_valid,
    input  logic                       ubit,
    input  logic                       irq_mask,
    input  logic                       status_rd,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [IU_BITS-1:0]         rd_data,
    output logic [$clog2(DEPTH+1)-1:0] msg_len,
    output logic                       irq_flag,
    output logic                       ovf_flag
);
    logic               byte_valid, msg_end, ovf_evt;
    logic [IU_BITS-1:0] byte_data;

    iu_deframe_fsm #(.IU_BITS(IU_BITS), .END_ZEROS(END_ZEROS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (ubit_valid),
        .bit_in     (ubit),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .msg_end    (msg_end)
    );

    iu_msg_store #(.DEPTH(DEPTH), .W(IU_BITS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .msg_end    (msg_end),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .msg_len    (msg_len),
        .ovf_evt    (ovf_evt)
    );

    iu_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_end   (msg_end),
        .ovf_evt   (ovf_evt),
        .irq_mask  (irq_mask),
        .status_rd (status_rd),
        .irq_flag  (irq_flag),
        .ovf_flag  (ovf_flag)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_flag && !ovf_flag && msg_len == '0));
endmodule

// File: tb/tb_iu_deframer.sv
module tb_iu_deframer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ubit_valid = 1'b0, ubit = 1'b0, irq_mask = 1'b0, status_rd = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [6:0] msg_len;
    logic       irq_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    iu_deframer dut (
        .clk(clk), .rst_n(rst_n), .ubit_valid(ubit_valid), .ubit(ubit),
        .irq_mask(irq_mask), .status_rd(status_rd), .rd_addr(rd_addr),
        .rd_data(rd_data), .msg_len(msg_len), .irq_flag(irq_flag), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {count, gap zeros, seed, mask}
    localparam logic [31:0] VEC [6] = '{
        {8'd1,  8'd0, 8'h05, 8'd1},
        {8'd4,  8'd8, 8'h20, 8'd1},
        {8'd10, 8'd3, 8'h40, 8'd0},
        {8'd2,  8'd1, 8'h7F, 8'd1},
        {8'd96, 8'd0, 8'h00, 8'd1},
        {8'd7,  8'd5, 8'h33, 8'd1}
    };

    function automatic logic [7:0] iu_val(input int seed, input int i);
        return 8'h80 | 8'((seed + i * 37) & 8'h7F);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ubit_valid = 1'b1;
        ubit = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ubit_valid = 1'b0;
            ubit = 1'b1;
        end
    endtask

    task automatic send_iu(input logic [7:0] v, input bit stall);
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i]);
            if (stall && i == 4) idle(1);   // R10 stall with ubit high
        end
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic end_msg();
        send_zeros(9);
        idle(4);
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        ubit_valid = 1'b0;
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic read_chk(input string req, input int addr, input int exp);
        rd_addr = 7'(addr);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic send_msg(input int cnt, input int gap, input int seed, input bit stall);
        for (int i = 0; i < cnt; i++) begin
            send_iu(iu_val(seed, i), stall && (i % 3 == 1));
            if (i != cnt - 1) send_zeros(gap);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_flag, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 len", msg_len, 0);
        // R11 out-of-range reads
        read_chk("R11 addr96", 96, 0);
        read_chk("R11 addr127", 127, 0);

        // Table-driven messages: R2 R3 R4 R6 R7 R10
        for (int v = 0; v < 6; v++) begin
            int cnt, gap, seed;
            cnt  = int'(VEC[v][31:24]);
            gap  = int'(VEC[v][23:16]);
            seed = int'(VEC[v][15:8]);
            irq_mask = VEC[v][0];
            pulse_rd();
            send_zeros(3 + v);            // R2 leading zeros in idle
            send_msg(cnt, gap, seed, gap[0]);
            end_msg();
            check("R6 len", msg_len, cnt);
            check("R7 irq vs mask", irq_flag, int'(VEC[v][0]));
            check("R9 no ovf", ovf_flag, 0);
            for (int i = 0; i < cnt; i++) read_chk("R3 R4 byte", i, iu_val(seed, i));
        end

        // R8 clear by status read
        irq_mask = 1'b1;
        pulse_rd();
        @(negedge clk);
        check("R8 irq cleared", irq_flag, 0);

        // R5 ping-pong: readable message holds while next fills
        send_msg(3, 2, 8'h15, 1'b0);
        end_msg();
        send_msg(2, 4, 8'h61, 1'b0);
        send_zeros(8);                   // R2 eight zeros do not end it
        idle(3);
        check("R5 len held", msg_len, 3);
        for (int i = 0; i < 3; i++) read_chk("R5 old byte", i, iu_val(8'h15, i));
        send_iu(iu_val(8'h61, 2), 1'b0);
        end_msg();
        check("R2 R6 len joined", msg_len, 3);
        for (int i = 0; i < 3; i++) read_chk("R2 new byte", i, iu_val(8'h61, i));

        // R8 set wins over a status read in the completion cycle
        pulse_rd();
        send_msg(1, 0, 8'h2A, 1'b0);
        send_zeros(9);
        @(negedge clk);
        ubit_valid = 1'b0;
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        check("R8 set wins", irq_flag, 1);
        @(negedge clk);
        check("R8 set holds", irq_flag, 1);

        // R9 overflow
        pulse_rd();
        send_msg(100, 0, 8'h09, 1'b0);
        end_msg();
        check("R9 len capped", msg_len, DEPTH);
        check("R9 ovf set", ovf_flag, 1);
        read_chk("R9 first", 0, iu_val(8'h09, 0));
        read_chk("R9 last kept", 95, iu_val(8'h09, 95));
        idle(5);
        check("R9 ovf sticky", ovf_flag, 1);
        pulse_rd();
        @(negedge clk);
        check("R9 ovf cleared", ovf_flag, 0);
        check("R8 irq cleared", irq_flag, 0);

        // R10 valid-low ones are ignored in idle
        idle(20);
        check("R10 len unchanged", msg_len, DEPTH);
        check("R10 no irq", irq_flag, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule